// File: doc/BRIEF.md
# Self-Programming Command Control Register

This block holds the control word that software uses to start flash self-programming. Software writes a five-bit command code together with a ready-interrupt enable. The command then stays armed for a short window. If the CPU raises its store-program strobe inside that window, the block carries out one of five actions:

- load one word into the temporary page buffer,
- erase a page,
- write a page,
- set the lock bits,
- re-enable reads of the read-while-write section.

Flash operations leave the block as a registered single-cycle command with an address and data word, sent to a flash controller. That controller reports the end of an erase or write on `fl_done`.

The block also keeps a section-busy flag. The flag is set when an erase or write targets a page inside the read-while-write section, and reads of that section must be blocked while it is set. A ready interrupt tells software that the enable bit has dropped.

Readback layout of `sw_rd_data`:

| Bit | Meaning |
|-----|---------|
| 0 | enable |
| 1 | erase |
| 2 | page write |
| 3 | lock set |
| 4 | section re-enable |
| 5 | reads 0 |
| 6 | section busy |
| 7 | interrupt enable |

Top module: `spm_ctrl`

## Requirements
- R1: A write always updates the interrupt enable (bit 7). The low five bits change only for the codes 5'b00001 (buffer load), 5'b00011 (page erase), 5'b00101 (page write), 5'b01001 (lock set) and 5'b10001 (section re-enable). Any other code leaves them as they were. Readback follows the bit layout table above.
- R2: A strobe is accepted on any of the four rising edges that follow the write edge. If none arrives, the low five bits clear on the fourth edge. A strobe after that has no effect.
- R3: An accepted buffer load produces a one-cycle `fl_cmd_valid` with `fl_cmd`=1, `fl_addr`=`addr_ptr`>>1 and `fl_data`=`data_pair`. The outputs appear right after the accepting edge, and the low five bits clear.
- R4: An accepted page erase gives `fl_cmd`=2 and an accepted page write gives `fl_cmd`=3. Both carry `fl_addr`=`addr_ptr`>>PAGE_SHIFT and `fl_data`=0.
- R5: During an erase or write, the enable bit and the command bit stay set until `fl_done`, and then both clear. Strobes are ignored in that time.
- R6: An erase or write on a page below RWW_LIMIT sets `rww_busy`. A page at or above RWW_LIMIT leaves it unchanged.
- R7: `rww_busy` clears on an accepted re-enable strobe, which issues no flash command. It also clears on an accepted buffer load.
- R8: Command writes made while an erase or write is in progress are ignored, and this includes the re-enable code. `rww_busy` stays set in that time.
- R9: Writing the re-enable code while a buffer load is armed replaces the load. The next strobe issues no flash command.
- R10: An accepted lock set gives `fl_cmd`=4, `fl_addr`=0 and `fl_data` equal to the low byte of `data_pair`, zero-extended.
- R11: `rdy_irq` equals interrupt enable AND `gie` AND NOT enable, and it is combinational in `gie`.
- R12: After reset, `sw_rd_data`, `fl_cmd_valid`, `rww_busy` and `rdy_irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_wr | input | 1 | Software register write strobe |
| sw_wr_code | input | 5 | Command code being written |
| sw_wr_ie | input | 1 | Ready-interrupt enable being written |
| sw_rd_data | output | 8 | Register readback |
| gie | input | 1 | Global interrupt flag |
| spm_strobe | input | 1 | Store-program strobe from the CPU |
| addr_ptr | input | ADDR_W | Byte address pointer |
| data_pair | input | DATA_W | Data operand pair |
| fl_done | input | 1 | Flash reports erase/write completion |
| fl_cmd_valid | output | 1 | One-cycle flash command pulse |
| fl_cmd | output | 3 | Flash command code |
| fl_addr | output | ADDR_W | Word index or page number |
| fl_data | output | DATA_W | Flash data |
| rww_busy | output | 1 | Read-while-write section busy |
| rdy_irq | output | 1 | Ready interrupt |

## Verification
The assertions assume a well-behaved flash controller. It raises `fl_done` only while an erase or write is outstanding, and only after the command pulse. The stimulus follows this rule by pulsing `fl_done` exactly once per accepted erase or write, and never at any other time.

The stimulus never asserts a register write and a strobe on the same edge. Every register write sits on a clean edge with no strobe beside it.

All 32 low-five-bit codes are swept, as are strobe delays from zero to six cycles and pages on both sides of the section boundary.

// File: rtl/spm_pkg.sv
package spm_pkg;
  typedef enum logic [2:0] {
    CMD_NONE  = 3'd0,
    CMD_LOAD  = 3'd1,
    CMD_ERASE = 3'd2,
    CMD_WRITE = 3'd3,
    CMD_LOCK  = 3'd4,
    CMD_REEN  = 3'd5
  } cmd_e;
endpackage

// File: rtl/spm_decode.sv
module spm_decode
  import spm_pkg::*;
(
  input  logic [4:0] code,
  output cmd_e       kind
);
  always_comb begin
    unique case (code)
      5'b00001: kind = CMD_LOAD;
      5'b00011: kind = CMD_ERASE;
      5'b00101: kind = CMD_WRITE;
      5'b01001: kind = CMD_LOCK;
      5'b10001: kind = CMD_REEN;
      default:  kind = CMD_NONE;
    endcase
  end
endmodule

// File: rtl/spm_window.sv
module spm_window #(
  parameter int WIN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic open,
  output logic last
);
  localparam int CNT_W = $clog2(WIN + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WIN);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load)        cnt_q <= CNT_MAX;
    else if (cnt_q != '0) cnt_q <= cnt_q - CNT_ONE;
  end

  assign open = (cnt_q != '0);
  assign last = (cnt_q == CNT_ONE);

  // R2: the window never holds longer than WIN cycles without a reload
  p_window_bound_r2: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_ONE));
endmodule

// File: rtl/spm_flash_if.sv
module spm_flash_if
  import spm_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int PAGE_SHIFT = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  cmd_e              kind,
  input  logic [ADDR_W-1:0] addr_ptr,
  input  logic [DATA_W-1:0] data_pair,
  output logic              fl_cmd_valid,
  output logic [2:0]        fl_cmd,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [DATA_W-1:0] fl_data
);
  localparam int PAD_W = DATA_W - 8;

  always_ff @(posedge clk) begin
    if (rst) begin
      fl_cmd_valid <= 1'b0;
      fl_cmd       <= 3'd0;
      fl_addr      <= '0;
      fl_data      <= '0;
    end else begin
      fl_cmd_valid <= issue;
      if (issue) begin
        fl_cmd <= kind;
        unique case (kind)
          CMD_LOAD: begin
            fl_addr <= addr_ptr >> 1;
            fl_data <= data_pair;
          end
          CMD_ERASE, CMD_WRITE: begin
            fl_addr <= addr_ptr >> PAGE_SHIFT;
            fl_data <= '0;
          end
          CMD_LOCK: begin
            fl_addr <= '0;
            fl_data <= {{PAD_W{1'b0}}, data_pair[7:0]};
          end
          default: begin
            fl_addr <= '0;
            fl_data <= '0;
          end
        endcase
      end
    end
  end

  // R3: each accepted strobe yields a single-cycle command pulse
  p_single_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    fl_cmd_valid |=> !fl_cmd_valid);
endmodule

// File: rtl/spm_ctrl.sv
module spm_ctrl
  import spm_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int PAGE_SHIFT = 7,
  parameter int RWW_LIMIT  = 384,
  parameter int WIN        = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_wr,
  input  logic [4:0]        sw_wr_code,
  input  logic              sw_wr_ie,
  output logic [7:0]        sw_rd_data,
  input  logic              gie,
  input  logic              spm_strobe,
  input  logic [ADDR_W-1:0] addr_ptr,
  input  logic [DATA_W-1:0] data_pair,
  input  logic              fl_done,
  output logic              fl_cmd_valid,
  output logic [2:0]        fl_cmd,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [DATA_W-1:0] fl_data,
  output logic              rww_busy,
  output logic              rdy_irq
);
  localparam logic [ADDR_W-1:0] RWW_PAGE_END = ADDR_W'(RWW_LIMIT);

  logic [4:0] ctl_q;
  logic       ie_q, rww_busy_q, op_busy_q;
  cmd_e       wr_kind, arm_kind;
  logic       wr_take, strobe_take, win_open, win_last, issue, in_rww;
  logic [ADDR_W-1:0] page;

  spm_decode u_dec_wr  (.code(sw_wr_code), .kind(wr_kind));
  spm_decode u_dec_arm (.code(ctl_q),      .kind(arm_kind));

  assign wr_take = sw_wr && (wr_kind != CMD_NONE) && !op_busy_q;

  spm_window #(.WIN(WIN)) u_win (
    .clk(clk), .rst(rst), .load(wr_take), .open(win_open), .last(win_last)
  );

  assign strobe_take = spm_strobe && win_open && ctl_q[0] && !op_busy_q && !wr_take;
  assign issue       = strobe_take && (arm_kind != CMD_REEN) && (arm_kind != CMD_NONE);
  assign page        = addr_ptr >> PAGE_SHIFT;
  assign in_rww      = (page < RWW_PAGE_END);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q      <= '0;
      ie_q       <= 1'b0;
      rww_busy_q <= 1'b0;
      op_busy_q  <= 1'b0;
    end else begin
      if (sw_wr) ie_q <= sw_wr_ie;
      if (wr_take) begin
        ctl_q <= sw_wr_code;
      end else if (op_busy_q) begin
        if (fl_done) begin
          ctl_q     <= '0;
          op_busy_q <= 1'b0;
        end
      end else if (strobe_take) begin
        unique case (arm_kind)
          CMD_ERASE, CMD_WRITE: begin
            op_busy_q <= 1'b1;
            if (in_rww) rww_busy_q <= 1'b1;
          end
          CMD_LOAD, CMD_REEN: begin
            rww_busy_q <= 1'b0;
            ctl_q      <= '0;
          end
          default: ctl_q <= '0;
        endcase
      end else if (win_last) begin
        ctl_q <= '0;
      end
    end
  end

  spm_flash_if #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_SHIFT(PAGE_SHIFT)
  ) u_fl (
    .clk(clk), .rst(rst), .issue(issue), .kind(arm_kind),
    .addr_ptr(addr_ptr), .data_pair(data_pair),
    .fl_cmd_valid(fl_cmd_valid), .fl_cmd(fl_cmd),
    .fl_addr(fl_addr), .fl_data(fl_data)
  );

  assign sw_rd_data = {ie_q, rww_busy_q, 1'b0, ctl_q};
  assign rww_busy   = rww_busy_q;
  assign rdy_irq    = ie_q && gie && !ctl_q[0];

  // R2: an armed idle command always sits inside an open window
  p_no_stale_arm_r2: assert property (@(posedge clk) disable iff (rst)
    (ctl_q[0] && !op_busy_q) |-> win_open);

  // R5: enable stays high for the whole erase/write
  p_en_held_r5: assert property (@(posedge clk) disable iff (rst)
    op_busy_q |-> ctl_q[0]);

  // R3: a flash command follows a strobe edge
  p_cmd_from_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    fl_cmd_valid |-> $past(spm_strobe));

  // R1: an illegal code written from idle leaves the command bits clear
  p_illegal_ignored_r1: assert property (@(posedge clk) disable iff (rst)
    (sw_wr && wr_kind == CMD_NONE && ctl_q == '0 && !op_busy_q) |=> (ctl_q == '0));

  // R8: the busy flag cannot drop during an erase/write
  p_busy_kept_r8: assert property (@(posedge clk) disable iff (rst)
    (op_busy_q && rww_busy_q) |=> rww_busy_q);
endmodule

// File: tb/sim_spm_ctrl.sv
`timescale 1ns/1ps
module sim_spm_ctrl;
  logic clk = 1'b0;
  logic rst, sw_wr, sw_wr_ie, gie, spm_strobe, fl_done;
  logic [4:0]  sw_wr_code;
  logic [15:0] addr_ptr, data_pair;
  logic [7:0]  sw_rd_data;
  logic        fl_cmd_valid, rww_busy, rdy_irq;
  logic [2:0]  fl_cmd;
  logic [15:0] fl_addr, fl_data;
  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  spm_ctrl u0 (
    .clk(clk), .rst(rst), .sw_wr(sw_wr), .sw_wr_code(sw_wr_code),
    .sw_wr_ie(sw_wr_ie), .sw_rd_data(sw_rd_data), .gie(gie),
    .spm_strobe(spm_strobe), .addr_ptr(addr_ptr), .data_pair(data_pair),
    .fl_done(fl_done), .fl_cmd_valid(fl_cmd_valid), .fl_cmd(fl_cmd),
    .fl_addr(fl_addr), .fl_data(fl_data), .rww_busy(rww_busy), .rdy_irq(rdy_irq)
  );

  task automatic step(); @(posedge clk); #1; endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic sw_write(input logic [4:0] code, input logic ie);
    sw_wr = 1'b1; sw_wr_code = code; sw_wr_ie = ie;
    step();
    sw_wr = 1'b0;
  endtask

  task automatic strobe(input logic [15:0] a, input logic [15:0] d);
    spm_strobe = 1'b1; addr_ptr = a; data_pair = d;
    step();
    spm_strobe = 1'b0;
  endtask

  function automatic bit legal(input logic [4:0] c);
    return c == 5'b00001 || c == 5'b00011 || c == 5'b00101 ||
           c == 5'b01001 || c == 5'b10001;
  endfunction

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; sw_wr = 0; sw_wr_ie = 0; sw_wr_code = 0; gie = 1;
    spm_strobe = 0; fl_done = 0; addr_ptr = 0; data_pair = 0;
    step(); step();
    rst = 1'b0;
    chk("R12 readback", sw_rd_data, 8'h00);
    chk("R12 valid", fl_cmd_valid, 0);
    chk("R12 busy", rww_busy, 0);
    chk("R12 irq", rdy_irq, 0);

    // R1: sweep every low-five-bit code
    for (int c = 0; c < 32; c++) begin
      sw_write(5'(c), 1'b1);
      chk("R1 code", sw_rd_data[4:0], legal(5'(c)) ? 32'(c) : 0);
      chk("R1 ie", sw_rd_data[7], 1);
      repeat (5) step();
    end

    // R11: interrupt combinations
    gie = 1; #1;
    chk("R11 ie gie idle", rdy_irq, 1);
    gie = 0; #1;
    chk("R11 gie low", rdy_irq, 0);
    gie = 1;
    sw_write(5'b00001, 1'b1);
    chk("R11 enable set", rdy_irq, 0);
    repeat (5) step();
    chk("R11 after expiry", rdy_irq, 1);
    sw_write(5'b00000, 1'b0);
    chk("R11 ie cleared", rdy_irq, 0);

    // R2/R3: window sweep with buffer loads
    for (int k = 0; k <= 6; k++) begin
      logic [15:0] a, d;
      a = 16'h0123 + 16'(k); d = 16'hA500 + 16'(k);
      sw_write(5'b00001, 1'b0);
      repeat (k) step();
      chk("R2 enable in window", sw_rd_data[0], (k <= 3) ? 1 : 0);
      strobe(a, d);
      chk("R2 accept", fl_cmd_valid, (k <= 3) ? 1 : 0);
      if (k <= 3) begin
        chk("R3 cmd", fl_cmd, 1);
        chk("R3 addr", fl_addr, 32'(a >> 1));
        chk("R3 data", fl_data, 32'(d));
        chk("R3 cleared", sw_rd_data[4:0], 0);
      end
      step();
      chk("R3 pulse ends", fl_cmd_valid, 0);
      repeat (5) step();
    end

    // R4/R5/R6/R7/R8: erase and write on both sides of the boundary
    for (int i = 0; i < 8; i++) begin
      logic [15:0] pg;
      logic [4:0]  code;
      bit in_sec;
      pg   = (i % 4 == 0) ? 16'd0 : (i % 4 == 1) ? 16'd383 : (i % 4 == 2) ? 16'd384 : 16'd500;
      code = (i < 4) ? 5'b00011 : 5'b00101;
      in_sec = (pg < 384);
      sw_write(code, 1'b0);
      strobe((pg << 7) | 16'h0015, 16'hFFFF);
      chk("R4 valid", fl_cmd_valid, 1);
      chk("R4 cmd", fl_cmd, (i < 4) ? 2 : 3);
      chk("R4 page", fl_addr, 32'(pg));
      chk("R4 data", fl_data, 0);
      chk("R6 busy", rww_busy, in_sec ? 1 : 0);
      step();
      chk("R5 held", sw_rd_data[4:0], 32'(code));
      sw_write(5'b10001, 1'b0);
      chk("R8 write ignored", sw_rd_data[4:0], 32'(code));
      strobe(16'h0000, 16'h1234);
      chk("R5 strobe ignored", fl_cmd_valid, 0);
      chk("R8 busy kept", rww_busy, in_sec ? 1 : 0);
      fl_done = 1'b1; step(); fl_done = 1'b0;
      chk("R5 done clears", sw_rd_data[4:0], 0);
      if (i % 2 == 0) begin
        sw_write(5'b10001, 1'b0);
        strobe(16'h0000, 16'h0000);
        chk("R7 reen no cmd", fl_cmd_valid, 0);
        chk("R7 reen clears", rww_busy, 0);
      end else begin
        sw_write(5'b00001, 1'b0);
        strobe(16'h0040, 16'h7777);
        chk("R7 load cmd", fl_cmd_valid, 1);
        chk("R7 load clears", rww_busy, 0);
      end
      repeat (5) step();
    end

    // R9: re-enable replaces an armed load
    sw_write(5'b00011, 1'b0);
    strobe(16'h0000, 16'h0000);
    step();
    fl_done = 1'b1; step(); fl_done = 1'b0;
    chk("R9 busy before", rww_busy, 1);
    sw_write(5'b00001, 1'b0);
    sw_write(5'b10001, 1'b0);
    chk("R9 rearmed", sw_rd_data[4:0], 5'b10001);
    strobe(16'h0100, 16'hBEEF);
    chk("R9 load dropped", fl_cmd_valid, 0);
    chk("R9 busy cleared", rww_busy, 0);
    repeat (5) step();

    // R10: lock set
    sw_write(5'b01001, 1'b0);
    strobe(16'hBEEF, 16'h5A3C);
    chk("R10 valid", fl_cmd_valid, 1);
    chk("R10 cmd", fl_cmd, 4);
    chk("R10 addr", fl_addr, 0);
    chk("R10 data", fl_data, 16'h003C);
    chk("R10 cleared", sw_rd_data[4:0], 0);
    repeat (3) step();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule